// File: doc/BRIEF.md
# Serial Transmit Byte Queue with Low-Water Trigger

This block sits between a processor's transmit data register and a serial line. Processor or DMA writes push bytes into a 16-entry queue. On each frame tick, while transmit is enabled, one byte is handed either to the serializer or, in loopback mode, to the receive side.

The block keeps three pieces of state about the queue. The first is a "room available" flag, set when the fill level drops to or below a selectable low-water mark. The second is a "drained" flag, set when the last byte leaves. The third is a transmit interrupt. Both flags and the interrupt are raised by departures and by a queue flush. Only writes tagged as coming from DMA take them down again, and only once the fill level climbs above the mark. The fill level is published in the upper byte of a shared 16-bit count word, and a neighbouring receive block fills the lower bits.

Top module: `sertx_fifo`

## Requirements
- R1: The queue holds at most 16 bytes. The fill level is never above 16, and a write that arrives while the level is 16 is dropped without disturbing the stored bytes.
- R2: Bytes leave in the order they were written. A departure in loopback-off mode shows up as a one-cycle `ser_valid` pulse with the byte on `ser_data`, in the cycle after the tick.
- R3: `low_sel` picks the low-water mark: 2'b00 gives 8, 2'b01 gives 4, 2'b10 gives 2, 2'b11 gives 1. After a departure that leaves the level at or below the mark, `room_flag` is 1.
- R4: A departure that leaves the queue empty sets `drained_flag`.
- R5: A departure that sets the flags also drives `tx_irq` to 1 when `irq_en` is 1. `tx_irq` is 0 in every cycle that follows a cycle with `irq_en` at 0.
- R6: A write with `wr_dma` at 0 never clears `room_flag` or `drained_flag`.
- R7: A write with `wr_dma` at 1 that leaves the level above the mark clears `room_flag`, `drained_flag` and `tx_irq`.
- R8: A `flush` pulse empties the queue, sets both flags and loads `tx_irq` with `irq_en`. It overrides any write or departure in the same cycle, and that cycle produces no output pulse.
- R9: A byte departs only in a cycle where both `frame_tick` and `tx_en` are 1.
- R10: With `loop_en` at 1, a departing byte appears on `loop_valid`/`loop_data` if `rx_en` is 1, and is discarded otherwise. `ser_valid` stays 0 in both cases.
- R11: `cnt_word[12:8]` carries the fill level, and every other bit of `cnt_word` is 0.
- R12: A tick on an empty queue produces no `ser_valid` or `loop_valid` pulse.
- R13: After reset the level is 0, both flags are 1, and `tx_irq`, `ser_valid` and `loop_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write a byte into the queue |
| wr_data | input | 8 | Byte to write |
| wr_dma | input | 1 | Marks the write as a DMA write |
| low_sel | input | 2 | Low-water mark select |
| tx_en | input | 1 | Transmit enable |
| loop_en | input | 1 | Loopback mode |
| rx_en | input | 1 | Receive enable, used in loopback |
| irq_en | input | 1 | Transmit interrupt enable |
| flush | input | 1 | Empty the queue |
| frame_tick | input | 1 | One pulse per frame time |
| ser_valid | output | 1 | Byte for the serializer is valid |
| ser_data | output | 8 | Byte for the serializer |
| loop_valid | output | 1 | Byte for the receive queue is valid |
| loop_data | output | 8 | Byte for the receive queue |
| room_flag | output | 1 | Level at or below the low-water mark |
| drained_flag | output | 1 | Queue drained |
| tx_irq | output | 1 | Transmit interrupt |
| cnt_word | output | 16 | Shared count word, fill level in bits 12:8 |

## Verification
The hardest state to reach is a queue sitting at 16 entries when a DMA write, a departure and sometimes a flush all land in the same cycle. At that point the discard rule, the flag clearing and the flush priority all meet. Random epochs with very rare ticks pile the queue up against its limit and keep it there. A directed fill with transmit disabled pushes a seventeenth byte and then drains the queue to check order and the empty-tick case.

// File: rtl/sertx_pkg.sv
// Shared types and helpers for the serial transmit queue.
package sertx_pkg;

    // Status pair kept by the flag controller.
    typedef struct packed {
        logic room;
        logic drained;
    } tx_flags_t;

    // Low-water mark: half the depth, halved again for each select step.
    function automatic int unsigned low_water(input logic [1:0] sel, input int unsigned depth);
        return (depth / 2) >> sel;
    endfunction

endpackage

// File: rtl/sertx_store.sv
// Circular byte storage with read/write pointers and a fill count.
// Assumes DEPTH is a power of two and that the caller never pushes
// when full or pops when empty; clr has priority over both.
module sertx_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic                       pop,
    input  logic [WIDTH-1:0]           wr_data,
    output logic [WIDTH-1:0]           head_data,
    output logic [$clog2(DEPTH):0]     count
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wp, rp;

    // Data array write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push && !clr) mem[wp] <= wr_data;
    end

    // Pointer and count bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // Oldest byte, presented for the next departure.
    assign head_data = mem[rp];

endmodule

// File: rtl/sertx_flags.sv
// Room/drained flags and transmit interrupt.
// Departures only raise, DMA writes past the mark only lower, flush raises.
module sertx_flags #(
    parameter int DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   pop,
    input  logic                   push,
    input  logic                   dma,
    input  logic                   irq_en,
    input  logic [$clog2(DEPTH):0] cnt_next,
    input  logic [$clog2(DEPTH):0] mark,
    output logic                   room_flag,
    output logic                   drained_flag,
    output logic                   tx_irq
);
    import sertx_pkg::*;

    tx_flags_t flags;
    logic      drain_hit, dma_hit;

    // Event decode against the level the queue will have after this cycle.
    always_comb begin
        drain_hit = pop && (cnt_next <= mark);
        dma_hit   = push && dma && (cnt_next > mark);
    end

    // Flag register update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            flags <= '{room: 1'b1, drained: 1'b1};
        end else if (drain_hit) begin
            flags.room <= 1'b1;
            if (cnt_next == '0) flags.drained <= 1'b1;
        end else if (dma_hit) begin
            flags <= '{room: 1'b0, drained: 1'b0};
        end
    end

    // Interrupt register update.
    always_ff @(posedge clk) begin
        if (!rst_n)          tx_irq <= 1'b0;
        else if (clr)        tx_irq <= irq_en;
        else if (!irq_en)    tx_irq <= 1'b0;
        else if (drain_hit)  tx_irq <= 1'b1;
        else if (dma_hit)    tx_irq <= 1'b0;
    end

    assign room_flag    = flags.room;
    assign drained_flag = flags.drained;

endmodule

// File: rtl/sertx_route.sv
// Registers a departing byte toward the serializer or the loopback path.
// A loopback byte with receive disabled is dropped.
module sertx_route #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop,
    input  logic             loop_en,
    input  logic             rx_en,
    input  logic [WIDTH-1:0] byte_in,
    output logic             ser_valid,
    output logic [WIDTH-1:0] ser_data,
    output logic             loop_valid,
    output logic [WIDTH-1:0] loop_data
);
    // Strobes last one cycle per departure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_valid  <= 1'b0;
            loop_valid <= 1'b0;
        end else begin
            ser_valid  <= pop && !loop_en;
            loop_valid <= pop && loop_en && rx_en;
        end
    end

    // Data held until the next departure on the same path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_data  <= '0;
            loop_data <= '0;
        end else if (pop) begin
            if (loop_en) loop_data <= byte_in;
            else         ser_data  <= byte_in;
        end
    end

endmodule

// File: rtl/sertx_fifo.sv
// Serial transmit queue top: accepts writes, releases one byte per enabled
// frame tick, maintains low-water flags and interrupt, publishes the count.
// Assumes frame_tick is a single-cycle pulse and DEPTH is a power of two.
module sertx_fifo #(
    parameter int DEPTH     = 16,
    parameter int WIDTH     = 8,
    parameter int FIELD_W   = 16,
    parameter int FIELD_LSB = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [WIDTH-1:0]   wr_data,
    input  logic               wr_dma,
    input  logic [1:0]         low_sel,
    input  logic               tx_en,
    input  logic               loop_en,
    input  logic               rx_en,
    input  logic               irq_en,
    input  logic               flush,
    input  logic               frame_tick,
    output logic               ser_valid,
    output logic [WIDTH-1:0]   ser_data,
    output logic               loop_valid,
    output logic [WIDTH-1:0]   loop_data,
    output logic               room_flag,
    output logic               drained_flag,
    output logic               tx_irq,
    output logic [FIELD_W-1:0] cnt_word
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic [CW-1:0]    count, cnt_next, mark;
    logic [WIDTH-1:0] head_data;
    logic             push_ok, pop_ok;

    // Accepted events; flush cancels both.
    always_comb begin
        push_ok  = wr_en && (count != CW'(DEPTH)) && !flush;
        pop_ok   = frame_tick && tx_en && (count != '0) && !flush;
        cnt_next = count + CW'(push_ok) - CW'(pop_ok);
        mark     = CW'(sertx_pkg::low_water(low_sel, DEPTH));
    end

    // Count placed in its field of the shared word.
    always_comb begin
        cnt_word = '0;
        cnt_word[FIELD_LSB +: CW] = count;
    end

    sertx_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(flush), .push(push_ok), .pop(pop_ok),
        .wr_data(wr_data), .head_data(head_data), .count(count)
    );

    sertx_flags #(.DEPTH(DEPTH)) u_flags (
        .clk(clk), .rst_n(rst_n), .clr(flush), .pop(pop_ok), .push(push_ok),
        .dma(wr_dma), .irq_en(irq_en), .cnt_next(cnt_next), .mark(mark),
        .room_flag(room_flag), .drained_flag(drained_flag), .tx_irq(tx_irq)
    );

    sertx_route #(.WIDTH(WIDTH)) u_route (
        .clk(clk), .rst_n(rst_n), .pop(pop_ok), .loop_en(loop_en), .rx_en(rx_en),
        .byte_in(head_data), .ser_valid(ser_valid), .ser_data(ser_data),
        .loop_valid(loop_valid), .loop_data(loop_data)
    );

endmodule

// File: rtl/sertx_fifo_chk.sv
// Property checker for sertx_fifo, attached by bind below.
module sertx_fifo_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          wr_dma,
    input logic          tx_en,
    input logic          irq_en,
    input logic          flush,
    input logic          frame_tick,
    input logic          ser_valid,
    input logic          loop_valid,
    input logic          room_flag,
    input logic          drained_flag,
    input logic          tx_irq,
    input logic [CW-1:0] count
);
    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    a_r1_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH) && wr_en && !(frame_tick && tx_en) && !flush) |=> count == CW'(DEPTH));

    a_r4_drained_implies_room: assert property (@(posedge clk) disable iff (!rst_n)
        drained_flag |-> room_flag);

    a_r5_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !tx_irq);

    a_r6_plain_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_dma && room_flag && drained_flag) |=> (room_flag && drained_flag));

    a_r8_flush_state: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0 && room_flag && drained_flag && !ser_valid && !loop_valid));

    a_r9_no_tx_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (!ser_valid && !loop_valid));

    a_r12_empty_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |=> (!ser_valid && !loop_valid));

endmodule

bind sertx_fifo sertx_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dma(wr_dma), .tx_en(tx_en),
    .irq_en(irq_en), .flush(flush), .frame_tick(frame_tick),
    .ser_valid(ser_valid), .loop_valid(loop_valid), .room_flag(room_flag),
    .drained_flag(drained_flag), .tx_irq(tx_irq), .count(count)
);

// File: tb/sertx_fifo_test.sv
`timescale 1ns/1ps
module sertx_fifo_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 0, wr_dma = 0, tx_en = 0, loop_en = 0, rx_en = 0;
    logic       irq_en = 0, flush = 0, frame_tick = 0;
    logic [7:0] wr_data = 0;
    logic [1:0] low_sel = 0;
    logic       ser_valid, loop_valid, room_flag, drained_flag, tx_irq;
    logic [7:0] ser_data, loop_data;
    logic [15:0] cnt_word;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Reference model state
    byte unsigned mq[$];
    bit m_room = 1, m_drained = 1, m_irq = 0;
    bit e_sv = 0, e_lv = 0;
    byte unsigned e_sd = 0, e_ld = 0;

    always #10 clk = ~clk;

    sertx_fifo uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_dma(wr_dma),
        .low_sel(low_sel), .tx_en(tx_en), .loop_en(loop_en), .rx_en(rx_en),
        .irq_en(irq_en), .flush(flush), .frame_tick(frame_tick),
        .ser_valid(ser_valid), .ser_data(ser_data), .loop_valid(loop_valid),
        .loop_data(loop_data), .room_flag(room_flag), .drained_flag(drained_flag),
        .tx_irq(tx_irq), .cnt_word(cnt_word)
    );

    function automatic int mark_of(input logic [1:0] s);
        case (s)
            2'b00: return 8;
            2'b01: return 4;
            2'b10: return 2;
            default: return 1;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Advance the model by one clock using the inputs currently driven.
    task automatic model_step();
        int n;
        bit pop, push;
        e_sv = 0; e_lv = 0;
        if (flush) begin
            mq.delete(); m_room = 1; m_drained = 1; m_irq = irq_en;
        end else begin
            pop  = frame_tick && tx_en && mq.size() > 0;
            push = wr_en && mq.size() < 16;
            if (pop) begin
                byte unsigned b = mq.pop_front();
                if (loop_en) begin
                    if (rx_en) begin e_lv = 1; e_ld = b; end
                end else begin
                    e_sv = 1; e_sd = b;
                end
            end
            if (push) mq.push_back(wr_data);
            n = mq.size();
            if (pop && n <= mark_of(low_sel)) begin
                m_room = 1;
                if (n == 0) m_drained = 1;
                if (irq_en) m_irq = 1;
            end else if (push && wr_dma && n > mark_of(low_sel)) begin
                m_room = 0; m_drained = 0; m_irq = 0;
            end
            if (!irq_en) m_irq = 0;
        end
    endtask

    task automatic compare_all();
        chk("R1", "level", int'(cnt_word[12:8]), mq.size());
        chk("R11", "other count bits", int'({cnt_word[15:13], cnt_word[7:0]}), 0);
        chk("R2", "ser_valid", ser_valid, e_sv);
        if (e_sv) chk("R2", "ser_data", ser_data, e_sd);
        chk("R10", "loop_valid", loop_valid, e_lv);
        if (e_lv) chk("R10", "loop_data", loop_data, e_ld);
        chk("R3", "room_flag", room_flag, m_room);
        chk("R4", "drained_flag", drained_flag, m_drained);
        chk("R5", "tx_irq", tx_irq, m_irq);
    endtask

    // One clock: inputs set at a falling edge, results sampled at the next.
    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle_inputs();
        wr_en = 0; wr_dma = 0; frame_tick = 0; flush = 0;
    endtask

    task automatic write_byte(input byte unsigned d, input bit dma);
        wr_en = 1; wr_data = d; wr_dma = dma; cycle(); idle_inputs();
    endtask

    task automatic tick_once();
        frame_tick = 1; cycle(); idle_inputs();
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd24681357);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R13: state right after reset release point
        chk("R13", "level", int'(cnt_word[12:8]), 0);
        chk("R13", "room_flag", room_flag, 1);
        chk("R13", "drained_flag", drained_flag, 1);
        chk("R13", "tx_irq", tx_irq, 0);
        chk("R13", "valids", {ser_valid, loop_valid}, 0);
        rst_n = 1;

        // R1/R9: fill with transmit disabled while ticking, then overfill
        irq_en = 1; low_sel = 2'b00;
        tx_en = 0;
        for (int i = 0; i < 17; i++) begin
            wr_en = 1; wr_data = 8'(8'h30 + i); frame_tick = 1; cycle();
        end
        idle_inputs();
        chk("R9", "level with tx disabled", int'(cnt_word[12:8]), 16);
        chk("R6", "room after plain writes", room_flag, 1);

        // R2/R12: drain in order, then an extra tick on an empty queue
        tx_en = 1;
        for (int i = 0; i < 16; i++) begin
            tick_once();
            chk("R2", "drain order", ser_data, 8'h30 + i);
        end
        chk("R4", "drained after last", drained_flag, 1);
        tick_once();
        chk("R12", "empty tick strobe", {ser_valid, loop_valid}, 0);

        // R7: DMA writes past mark 2 clear flags and irq
        low_sel = 2'b10;
        for (int i = 0; i < 3; i++) write_byte(8'(8'hA0 + i), 1'b1);
        chk("R7", "room cleared", room_flag, 0);
        chk("R7", "drained cleared", drained_flag, 0);
        chk("R7", "irq cleared", tx_irq, 0);
        tick_once();
        chk("R3", "room at mark 2", room_flag, 1);
        chk("R5", "irq raised", tx_irq, 1);

        // R6: plain writes above the mark leave the flags alone
        for (int i = 0; i < 4; i++) write_byte(8'(8'hB0 + i), 1'b0);
        chk("R6", "room kept", room_flag, 1);

        // R8: flush with a write and tick in the same cycle
        irq_en = 1; wr_en = 1; wr_data = 8'h55; frame_tick = 1; flush = 1; cycle(); idle_inputs();
        chk("R8", "level after flush", int'(cnt_word[12:8]), 0);
        chk("R8", "irq after flush", tx_irq, 1);
        chk("R8", "no strobe", ser_valid, 0);

        // R10: loopback with and without receive enabled
        loop_en = 1; rx_en = 1;
        write_byte(8'h77, 1'b0); write_byte(8'h78, 1'b0);
        tick_once();
        chk("R10", "loop byte", loop_data, 8'h77);
        rx_en = 0; tick_once();
        chk("R10", "dropped byte", {ser_valid, loop_valid}, 0);
        loop_en = 0;

        // Random epochs with varied tick density
        for (int ep = 0; ep < 20; ep++) begin
            int tick_pct = (ep % 4 == 0) ? 3 : 20 + $urandom_range(0, 60);
            low_sel = 2'($urandom_range(0, 3));
            loop_en = ($urandom_range(0, 99) < 20);
            rx_en   = ($urandom_range(0, 99) < 70);
            for (int c = 0; c < 250; c++) begin
                wr_en      = ($urandom_range(0, 99) < 50);
                wr_data    = 8'($urandom);
                wr_dma     = ($urandom_range(0, 99) < 35);
                frame_tick = ($urandom_range(0, 99) < tick_pct);
                tx_en      = ($urandom_range(0, 99) < 90);
                irq_en     = ($urandom_range(0, 99) < 85);
                flush      = ($urandom_range(0, 999) < 8);
                cycle();
            end
        end
        idle_inputs();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule